// File: doc/BRIEF.md
# ECC Error Capture Status Registers

This block is the error-logging register bank that sits beside a DRAM controller's ECC checker. It turns single-cycle event pulses into sticky status flags. The sources are correctable and uncorrectable ECC errors, a refresh timeout, a locked access that targeted non-DRAM space, and a thermal sensor trip. For the ECC events it also records the failing cache-line address, the channel and the ECC syndrome. Software polls the flags through a word-addressed register port and clears them by writing ones. A command register selects which event classes drive the level-sensitive system-error output.

The log keeps the most serious error. A correctable error fills it only when no ECC flag is pending. An uncorrectable error replaces the details of a pending correctable error. A second uncorrectable error leaves the first one's details in place until software clears the flag. Register reads are combinational. Writes and event captures take effect at the next rising clock edge.

Top module: `ecclog_top`

## Requirements
- R1: After reset every register reads zero and `serr` is low.
- R2: A pulse on an event input sets its status flag at the next edge. The status register at offset 0x00 uses bit 0 for correctable ECC, bit 1 for uncorrectable ECC, bit 8 for refresh timeout, bit 9 for locked non-DRAM access and bit 11 for thermal. All other bits read zero.
- R3: Writing the status register clears every flag whose write-data bit is 1 and leaves flags written with 0 unchanged. Bits outside mask 0x0B03 have no effect.
- R4: When an event sets a flag in the same cycle that software clears it, the flag ends up set.
- R5: The logs are arranged as follows. The address log at 0x08 holds failing address bits 31:7 in bits 31:7, zeros in bits 6:1 and the channel in bit 0. The register at 0x0C holds address bit 32 in bit 0 and zeros above it. The syndrome register at 0x10 holds the 8-bit syndrome. A correctable error that arrives with no ECC flag set loads all three.
- R6: A correctable error that arrives while either ECC flag is set leaves all three logs unchanged.
- R7: An uncorrectable error that arrives while the uncorrectable flag is clear loads all three logs, even when a correctable error is already logged.
- R8: An uncorrectable error that arrives while the uncorrectable flag is set leaves all three logs unchanged.
- R9: The command register at 0x04 stores write-data bits 0, 1, 8, 9 and 11. Its other bits read zero.
- R10: `serr` is high exactly when some status flag and the command bit at the same position are both set.
- R11: Writes to the log registers at 0x08, 0x0C and 0x10 have no effect.
- R12: Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| ce_evt | input | 1 | Correctable ECC error pulse |
| ue_evt | input | 1 | Uncorrectable ECC error pulse |
| rfsh_tmo_evt | input | 1 | Refresh timeout pulse |
| lock_evt | input | 1 | Locked access to non-DRAM pulse |
| therm_evt | input | 1 | Thermal sensor event pulse |
| evt_line | input | PHYS_AW-GRAIN_LG | Failing address shifted right by GRAIN_LG |
| evt_chan | input | 1 | Failing channel |
| evt_syn | input | SYN_W | ECC syndrome of the event |
| serr | output | 1 | System-error level |

## Verification
The bench goes after the log-priority corner cases. A design that compared against the wrong flag would let a second correctable error, or a second uncorrectable error, overwrite the first error's address. A design that gave correctable errors priority would keep stale details after an uncorrectable error. The bench also drives an event and a clear for the same bit in the same cycle; a clear-wins design would silently lose that event. It writes zeros and reserved bits to check that write-one-to-clear touches nothing else. It writes to the log offsets, which a writable-log design would corrupt. It sweeps the command register so that an output tied to the wrong bit or to raw status would show up on `serr`.

// File: rtl/ecclog_pkg.sv
package ecclog_pkg;
   localparam int STS_W = 16;
   localparam int B_CE  = 0;
   localparam int B_UE  = 1;
   localparam int B_RTO = 8;
   localparam int B_LCK = 9;
   localparam int B_THM = 11;
   localparam logic [STS_W-1:0] ERR_MASK = 16'h0B03;

   localparam logic [7:0] OFS_STS  = 8'h00;
   localparam logic [7:0] OFS_CMD  = 8'h04;
   localparam logic [7:0] OFS_ALOG = 8'h08;
   localparam logic [7:0] OFS_AEXT = 8'h0C;
   localparam logic [7:0] OFS_SYN  = 8'h10;

   typedef enum logic [2:0] {
      SEL_STS, SEL_CMD, SEL_ALOG, SEL_AEXT, SEL_SYN, SEL_NONE
   } reg_sel_e;
endpackage

// File: rtl/ecclog_flags.sv
module ecclog_flags #(
   parameter int W = 16,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] sts_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (MASK[i]) begin : g_live
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_q <= 1'b0;
            else if (set_i[i]) flag_q <= 1'b1;
            else if (clr_i[i]) flag_q <= 1'b0;
         end
         assign sts_o[i] = flag_q;
      end else begin : g_rsvd
         logic unused_set;
         logic unused_clr;
         assign unused_set = set_i[i];
         assign unused_clr = clr_i[i];
         assign sts_o[i]   = 1'b0;
      end
   end
endmodule

// File: rtl/ecclog_capture.sv
module ecclog_capture #(
   parameter int PHYS_AW  = 33,
   parameter int GRAIN_LG = 7,
   parameter int SYN_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ce_i,
   input  logic                        ue_i,
   input  logic                        ce_held_i,
   input  logic                        ue_held_i,
   input  logic [PHYS_AW-GRAIN_LG-1:0] line_i,
   input  logic                        chan_i,
   input  logic [SYN_W-1:0]            syn_i,
   output logic [31:0]                 alog_o,
   output logic [7:0]                  aext_o,
   output logic [SYN_W-1:0]            syn_o
);
   localparam int LINE_W = PHYS_AW - GRAIN_LG;
   localparam int LO_W   = 32 - GRAIN_LG;
   localparam int EXT_W  = PHYS_AW - 32;

   logic            take_ue, take_ce, take;
   logic [LO_W-1:0] hi_q;
   logic            chan_q;
   logic [SYN_W-1:0] syn_q;

   // Uncorrectable outranks everything not already uncorrectable;
   // correctable only fills an empty log.
   assign take_ue = ue_i && !ue_held_i;
   assign take_ce = ce_i && !ue_i && !ce_held_i && !ue_held_i;
   assign take    = take_ue || take_ce;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= '0;
         chan_q <= 1'b0;
         syn_q  <= '0;
      end else if (take) begin
         hi_q   <= line_i[LO_W-1:0];
         chan_q <= chan_i;
         syn_q  <= syn_i;
      end
   end

   assign alog_o = {hi_q, {(GRAIN_LG-1){1'b0}}, chan_q};
   assign syn_o  = syn_q;

   if (EXT_W > 0) begin : g_ext
      logic [EXT_W-1:0] ext_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    ext_q <= '0;
         else if (take) ext_q <= line_i[LINE_W-1:LO_W];
      end
      assign aext_o = 8'(ext_q);
   end else begin : g_noext
      assign aext_o = 8'h00;
   end
endmodule

// File: rtl/ecclog_regs.sv
module ecclog_regs
   import ecclog_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int SYN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [STS_W-1:0]  wdata_i,
   input  logic              we_i,
   input  logic [STS_W-1:0]  sts_i,
   input  logic [31:0]       alog_i,
   input  logic [7:0]        aext_i,
   input  logic [SYN_W-1:0]  syn_i,
   output logic [STS_W-1:0]  cmd_o,
   output logic [STS_W-1:0]  clr_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFS_STS);
   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
   localparam logic [ADDR_W-1:0] A_ALOG = ADDR_W'(OFS_ALOG);
   localparam logic [ADDR_W-1:0] A_AEXT = ADDR_W'(OFS_AEXT);
   localparam logic [ADDR_W-1:0] A_SYN  = ADDR_W'(OFS_SYN);

   reg_sel_e         sel;
   logic [STS_W-1:0] cmd_q;

   always_comb begin
      unique case (addr_i)
         A_STS:   sel = SEL_STS;
         A_CMD:   sel = SEL_CMD;
         A_ALOG:  sel = SEL_ALOG;
         A_AEXT:  sel = SEL_AEXT;
         A_SYN:   sel = SEL_SYN;
         default: sel = SEL_NONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cmd_q <= '0;
      else if (we_i && sel == SEL_CMD) cmd_q <= wdata_i & ERR_MASK;
   end

   assign cmd_o = cmd_q;
   assign clr_o = (we_i && sel == SEL_STS) ? (wdata_i & ERR_MASK) : '0;

   always_comb begin
      case (sel)
         SEL_STS:  rdata_o = DATA_W'(sts_i);
         SEL_CMD:  rdata_o = DATA_W'(cmd_q);
         SEL_ALOG: rdata_o = DATA_W'(alog_i);
         SEL_AEXT: rdata_o = DATA_W'(aext_i);
         SEL_SYN:  rdata_o = DATA_W'(syn_i);
         default:  rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/ecclog_top.sv
module ecclog_top
   import ecclog_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int PHYS_AW  = 33,
   parameter int GRAIN_LG = 7,
   parameter int SYN_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic [DATA_W-1:0]           reg_wdata,
   input  logic                        reg_we,
   output logic [DATA_W-1:0]           reg_rdata,
   input  logic                        ce_evt,
   input  logic                        ue_evt,
   input  logic                        rfsh_tmo_evt,
   input  logic                        lock_evt,
   input  logic                        therm_evt,
   input  logic [PHYS_AW-GRAIN_LG-1:0] evt_line,
   input  logic                        evt_chan,
   input  logic [SYN_W-1:0]            evt_syn,
   output logic                        serr
);
   if (ADDR_W < 5)                     begin : g_bad_aw  $error("ADDR_W must reach offset 0x10"); end
   if (DATA_W < 32)                    begin : g_bad_dw  $error("DATA_W must be at least 32"); end
   if (PHYS_AW < 32 || PHYS_AW > 40)   begin : g_bad_pa  $error("PHYS_AW must be 32..40"); end
   if (GRAIN_LG < 2 || GRAIN_LG > 16)  begin : g_bad_gr  $error("GRAIN_LG must be 2..16"); end
   if (SYN_W < 1 || SYN_W > 32)        begin : g_bad_sy  $error("SYN_W must be 1..32"); end

   logic [STS_W-1:0] set_w, clr_w, sts_w, cmd_w;
   logic [31:0]      alog_w;
   logic [7:0]       aext_w;
   logic [SYN_W-1:0] syn_w;
   logic             unused_wdata;

   assign unused_wdata = ^reg_wdata[DATA_W-1:STS_W];

   always_comb begin
      set_w        = '0;
      set_w[B_CE]  = ce_evt;
      set_w[B_UE]  = ue_evt;
      set_w[B_RTO] = rfsh_tmo_evt;
      set_w[B_LCK] = lock_evt;
      set_w[B_THM] = therm_evt;
   end

   ecclog_flags #(.W(STS_W), .MASK(ERR_MASK)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_w),
      .clr_i (clr_w),
      .sts_o (sts_w)
   );

   ecclog_capture #(.PHYS_AW(PHYS_AW), .GRAIN_LG(GRAIN_LG), .SYN_W(SYN_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_i      (ce_evt),
      .ue_i      (ue_evt),
      .ce_held_i (sts_w[B_CE]),
      .ue_held_i (sts_w[B_UE]),
      .line_i    (evt_line),
      .chan_i    (evt_chan),
      .syn_i     (evt_syn),
      .alog_o    (alog_w),
      .aext_o    (aext_w),
      .syn_o     (syn_w)
   );

   ecclog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYN_W(SYN_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (reg_addr),
      .wdata_i (reg_wdata[STS_W-1:0]),
      .we_i    (reg_we),
      .sts_i   (sts_w),
      .alog_i  (alog_w),
      .aext_i  (aext_w),
      .syn_i   (syn_w),
      .cmd_o   (cmd_w),
      .clr_o   (clr_w),
      .rdata_o (reg_rdata)
   );

   assign serr = |(sts_w & cmd_w);
endmodule

// File: rtl/ecclog_chk.sv
module ecclog_chk
   import ecclog_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int PHYS_AW  = 33,
   parameter int GRAIN_LG = 7,
   parameter int SYN_W    = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        ce_evt,
   input logic                        ue_evt,
   input logic                        reg_we,
   input logic [ADDR_W-1:0]           reg_addr,
   input logic [STS_W-1:0]            wlo,
   input logic [PHYS_AW-GRAIN_LG-1:0] evt_line,
   input logic [STS_W-1:0]            sts_q,
   input logic [STS_W-1:0]            cmd_q,
   input logic [31:0]                 alog_q,
   input logic [SYN_W-1:0]            syn_q,
   input logic                        serr
);
   localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
   localparam int LO_W = 32 - GRAIN_LG;

   // R2
   ce_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce_evt |=> sts_q[B_CE]);

   // R3
   w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_STS && wlo[B_CE] && !ce_evt) |=> !sts_q[B_CE]);

   // R4
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_evt && reg_we && reg_addr == A_STS && wlo[B_UE]) |=> sts_q[B_UE]);

   // R6
   ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_evt && !ue_evt && (sts_q[B_CE] || sts_q[B_UE])) |=> ($stable(alog_q) && $stable(syn_q)));

   // R7
   ue_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_evt && !sts_q[B_UE]) |=> (alog_q[31:GRAIN_LG] == $past(evt_line[LO_W-1:0])));

   // R8
   ue_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_evt && sts_q[B_UE]) |=> ($stable(alog_q) && $stable(syn_q)));

   // R10
   serr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == '0) |-> !serr);
endmodule

bind ecclog_top ecclog_chk #(
   .ADDR_W(ADDR_W), .PHYS_AW(PHYS_AW), .GRAIN_LG(GRAIN_LG), .SYN_W(SYN_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ce_evt   (ce_evt),
   .ue_evt   (ue_evt),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .wlo      (reg_wdata[15:0]),
   .evt_line (evt_line),
   .sts_q    (sts_w),
   .cmd_q    (cmd_w),
   .alog_q   (alog_w),
   .syn_q    (syn_w),
   .serr     (serr)
);

// File: tb/ecclog_top_bench.sv
`timescale 1ns/10ps
module ecclog_top_bench;
   localparam int ADDR_W = 8, DATA_W = 32, PHYS_AW = 33, GRAIN_LG = 7, SYN_W = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0, reg_rdata;
   logic reg_we = 1'b0;
   logic ce_evt = 0, ue_evt = 0, rfsh_tmo_evt = 0, lock_evt = 0, therm_evt = 0;
   logic [PHYS_AW-GRAIN_LG-1:0] evt_line = '0;
   logic evt_chan = 0;
   logic [SYN_W-1:0] evt_syn = '0;
   logic serr;

   ecclog_top u_ecclog_top (.*);

   int n_chk = 0, n_fail = 0;
   logic [15:0] m_sts = '0, m_cmd = '0;
   logic [31:0] m_alog = '0;
   logic [7:0]  m_ext = '0, m_syn = '0;

   function automatic logic [15:0] keep_mask(input logic [15:0] v);
      return v & 16'h0B03;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.2;
      d = reg_rdata;
   endtask

   task automatic read_all(input string ctx);
      logic [31:0] d;
      rd(8'h00, d); chk({ctx, " R2 status"}, d, {16'h0, m_sts});
      rd(8'h04, d); chk({ctx, " R9 command"}, d, {16'h0, m_cmd});
      rd(8'h08, d); chk({ctx, " R5 addr log"}, d, m_alog);
      rd(8'h0C, d); chk({ctx, " R5 ext addr"}, d, {24'h0, m_ext});
      rd(8'h10, d); chk({ctx, " R5 syndrome"}, d, {24'h0, m_syn});
      rd(8'h14, d); chk({ctx, " R12 unmapped"}, d, 32'h0);
      chk({ctx, " R10 serr"}, {31'h0, serr}, {31'h0, |(m_sts & m_cmd)});
   endtask

   // One clock: drive at negedge, model at posedge, check at next negedge.
   task automatic step(input string ctx, input logic ce, input logic ue, input logic rto,
                       input logic lck, input logic thm, input logic [32:0] ba,
                       input logic ch, input logic [7:0] sy, input logic we,
                       input logic [7:0] wa, input logic [31:0] wd);
      logic [15:0] clr, set;
      ce_evt = ce; ue_evt = ue; rfsh_tmo_evt = rto; lock_evt = lck; therm_evt = thm;
      evt_line = ba[32:7]; evt_chan = ch; evt_syn = sy;
      reg_we = we; reg_addr = wa; reg_wdata = wd;
      @(posedge clk);
      if (ue && !m_sts[1] || ce && !ue && !m_sts[0] && !m_sts[1]) begin
         m_alog = {ba[31:7], 6'b0, ch};
         m_ext  = {7'b0, ba[32]};
         m_syn  = sy;
      end
      clr = (we && wa == 8'h00) ? keep_mask(wd[15:0]) : 16'h0;
      set = '0;
      set[0] = ce; set[1] = ue; set[8] = rto; set[9] = lck; set[11] = thm;
      m_sts = (m_sts & ~clr) | set;
      if (we && wa == 8'h04) m_cmd = keep_mask(wd[15:0]);
      @(negedge clk);
      ce_evt = 0; ue_evt = 0; rfsh_tmo_evt = 0; lock_evt = 0; therm_evt = 0; reg_we = 0;
      read_all(ctx);
   endtask

   task automatic idle_wr(input string ctx, input logic [7:0] wa, input logic [31:0] wd);
      step(ctx, 0, 0, 0, 0, 0, 33'h0, 0, 8'h0, 1, wa, wd);
   endtask

   initial begin
      #(8.0 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      read_all("R1 reset");

      // R5: first correctable error loads the logs
      step("R5 ce", 1, 0, 0, 0, 0, 33'h1_2345_67C9, 1, 8'h5A, 0, 8'h0, 0);
      chk("R5 addr log layout", m_alog, 32'h2345_6781);
      // R6: second correctable error must not disturb
      step("R6 ce hold", 1, 0, 0, 0, 0, 33'h0_0BAD_0000, 0, 8'h11, 0, 8'h0, 0);
      // R7: uncorrectable replaces a correctable log
      step("R7 ue over ce", 0, 1, 0, 0, 0, 33'h0_CAFE_0080, 0, 8'hE7, 0, 8'h0, 0);
      // R8: later uncorrectable keeps the first
      step("R8 ue keep", 0, 1, 0, 0, 0, 33'h1_FFFF_FF80, 1, 8'h33, 0, 8'h0, 0);
      // R6: correctable while uncorrectable pending
      step("R6 ce under ue", 1, 0, 0, 0, 0, 33'h1_0000_0100, 1, 8'h44, 0, 8'h0, 0);
      // R11: log registers ignore writes
      idle_wr("R11 alog wr", 8'h08, 32'hFFFF_FFFF);
      idle_wr("R11 ext wr", 8'h0C, 32'hFFFF_FFFF);
      idle_wr("R11 syn wr", 8'h10, 32'hFFFF_FFFF);
      // R3: zeros leave flags alone, ones clear only the mask
      idle_wr("R3 zero write", 8'h00, 32'h0);
      idle_wr("R3 clear ce", 8'h00, 32'hFFFF_F4FD);
      idle_wr("R3 clear all", 8'h00, 32'hFFFF_FFFF);
      // R2: each of the other sources
      step("R2 rto", 0, 0, 1, 0, 0, 33'h0, 0, 8'h0, 0, 8'h0, 0);
      step("R2 lock", 0, 0, 0, 1, 0, 33'h0, 0, 8'h0, 0, 8'h0, 0);
      step("R2 therm", 0, 0, 0, 0, 1, 33'h0, 0, 8'h0, 0, 8'h0, 0);
      // R4: set beats clear in the same cycle
      step("R4 set wins", 0, 0, 1, 0, 1, 33'h0, 0, 8'h0, 1, 8'h00, 32'h0000_0B03);
      // R9, R10: command masking and the system-error level
      idle_wr("R9 cmd all", 8'h04, 32'hFFFF_FFFF);
      idle_wr("R10 cmd lock only", 8'h04, 32'h0000_0200);
      idle_wr("R10 clear others", 8'h00, 32'h0000_0900);
      idle_wr("R10 clear lock", 8'h00, 32'h0000_0200);

      for (int i = 0; i < 600; i++) begin
         logic [7:0] wa;
         logic [31:0] pick;
         pick = $urandom;
         case (pick[2:0])
            3'd0: wa = 8'h00; 3'd1: wa = 8'h04; 3'd2: wa = 8'h08;
            3'd3: wa = 8'h0C; 3'd4: wa = 8'h10; default: wa = 8'h00;
         endcase
         step("rand", ($urandom % 4) == 0, ($urandom % 7) == 0, ($urandom % 5) == 0,
              ($urandom % 5) == 0, ($urandom % 5) == 0, {$urandom, $urandom} & 33'h1_FFFF_FFFF,
              pick[3], 8'($urandom), ($urandom % 3) == 0, wa, $urandom);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule